// File: doc/BRIEF.md
# Burst DMA Channel Between a Peripheral FIFO and Memory

The block is one DMA channel that moves data between a fixed peripheral FIFO and system memory. Every memory access is one beat of up to 32 bytes, carrying an address and per-byte lane enables. Software programs the channel through a small 32-bit register window. That window holds:

- a source address and a destination address;
- a count of beats, kept in beat units rather than bytes;
- a lane mask that trims the last beat;
- a control word.

A direction bit in the control word picks the flow. In FIFO-to-memory mode the channel takes a word from the FIFO and writes it to the destination address. In memory-to-FIFO mode it reads the source address and offers the data to the FIFO. Only the address on the memory side steps after each completed beat. Software can therefore work out the bytes left from how far that address has moved.

The transfer finishes in one of two ways. Either the count runs down to zero, or software forces an end. Software usually forces an end after the FIFO reports an empty or short condition. A level interrupt, gated by per-event enables, reports both kinds of end and the FIFO condition. A global enable input can stall all memory traffic. An error response from the memory side halts the channel and raises a sticky error flag.

Top module: `fifo_dma_chan`

## Requirements
- R1: After reset every register reads 0, and `irq_o`, `addr_err_o`, `mem_req_o`, `fifo_in_ready_o` and `fifo_out_valid_o` are low.
- R2: Register byte offsets:
  - 0x00: source address, 32 bits, read back as written.
  - 0x04: destination address, 32 bits, read back as written.
  - 0x08: beat count. Only bits 23:0 are stored; the upper bits read 0.
  - 0x14: control word.
  - 0x18: last-beat lane mask, 32 bits, read back as written.
  - Any other offset reads 0.
- R3: Control bit 3 = 0 selects FIFO-to-memory. Each word accepted from the FIFO becomes exactly one write request (`mem_we_o`=1) at the destination address, carrying that word. After each acknowledge the destination address grows by the beat size and the count drops by 1. The source address is unchanged.
- R4: Control bit 3 = 1 selects memory-to-FIFO. Each beat is one read request (`mem_we_o`=0) at the source address, which grows by the beat size on acknowledge. The read data is then held on `fifo_out_data_o` with `fifo_out_valid_o` high until `fifo_out_ready_i`. The count drops by 1 on that handshake.
- R5: The channel is busy while enable (control bit 0) is 1 and end (control bit 1) is 0. When the count reaches 0, bit 1 is set and no further request is made. Enabling the channel with a count of 0 sets bit 1 without any request.
- R6: Lane masking on the last beat (count = 1): byte lane i of `mem_be_o` is enabled only if mask bit 31−i is set, so valid bytes are marked from the MSB down. On earlier beats every lane of the beat is enabled.
- R7: Beat size comes from control bits 7:6: 00 = 8 bytes, 01 = 16 bytes, 10 or 11 = 32 bytes. The beat size sets both the address step and the enabled low byte lanes.
- R8: In FIFO-to-memory mode, while the channel is busy, waiting, and `fifo_null_i` is high, the null flag (control bit 12) is set.
- R9: Writing 1 to control bit 24 while busy ends the transfer. Both bit 1 and the stop flag (bit 2) are set, and no further request is made.
- R10: Flags 1, 2 and 12 are cleared by writing 0 to them; writing 1 leaves them unchanged. Bit 24 reads as a pending forced-end request.
- R11: `irq_o` = (bit 5 AND (bit 1 OR bit 2)) OR (bit 16 AND bit 12). It is a level and stays high until software clears the flags.
- R12: While `glob_en_i` is low, the channel raises no memory request and accepts no FIFO word.
- R13: An acknowledge with `mem_err_i` high does the following:
  - clears control bit 0;
  - sets `addr_err_o`;
  - leaves the address and count unchanged.
  - `addr_err_o` stays high until a control write with bit 0 = 1.
- R14: Clearing control bit 0 in mid-transfer abandons the pending beat. No FIFO push, memory request or count change follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| glob_en_i | input | 1 | Global enable for memory traffic |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on `reg_addr_i` |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr_o | output | 32 | Beat address |
| mem_be_o | output | 32 | Byte lane enables, bit i = byte i |
| mem_wdata_o | output | 256 | Write data |
| mem_ack_i | input | 1 | Beat accepted and completed this cycle |
| mem_err_i | input | 1 | Error response, valid with `mem_ack_i` |
| mem_rdata_i | input | 256 | Read data, valid with `mem_ack_i` |
| fifo_in_valid_i | input | 1 | FIFO offers a word |
| fifo_in_data_i | input | 256 | Word from the FIFO |
| fifo_in_ready_o | output | 1 | Channel accepts the FIFO word |
| fifo_null_i | input | 1 | FIFO reports an empty or short condition |
| fifo_out_valid_o | output | 1 | Word offered to the FIFO |
| fifo_out_data_o | output | 256 | Word to the FIFO |
| fifo_out_ready_i | input | 1 | FIFO takes the word |
| irq_o | output | 1 | Level interrupt |
| addr_err_o | output | 1 | Sticky bus error flag |

## Verification
Register writes are seen on the clock edge after the strobe. Read data is combinational and is sampled 1 ns after the falling edge. Flag and interrupt results follow:

- a control write: one cycle after it;
- a FIFO null report: one cycle after it;
- a forced-end request: two cycles after it.

A FIFO-to-memory beat takes two cycles: accept, then request with acknowledge. A memory-to-FIFO beat takes a request cycle and then at least one push cycle. For that reason, the bench waits a fixed margin of cycles that covers every beat before it compares addresses, counts and flags. Memory requests and FIFO pushes are logged 1 ns after each falling edge. These inputs are only changed on that edge, so each log entry matches what the design sees at the next rising edge.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int REG_W = 32;

  localparam logic [4:0] OFF_SRC  = 5'h00;
  localparam logic [4:0] OFF_DST  = 5'h04;
  localparam logic [4:0] OFF_CNT  = 5'h08;
  localparam logic [4:0] OFF_CTL  = 5'h14;
  localparam logic [4:0] OFF_MASK = 5'h18;

  localparam int B_EN    = 0;
  localparam int B_END   = 1;
  localparam int B_STOP  = 2;
  localparam int B_DIR   = 3;
  localparam int B_IE    = 5;
  localparam int B_SZ    = 6;
  localparam int B_NULL  = 12;
  localparam int B_NULLE = 16;
  localparam int B_FORCE = 24;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MEM,
    ST_PUSH
  } seq_st_e;
endpackage

// File: rtl/dmac_lanes.sv
module dmac_lanes #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 32
) (
  input  logic [1:0]            size_i,
  input  logic                  last_i,
  input  logic [DATA_BYTES-1:0] tend_i,
  output logic [DATA_BYTES-1:0] be_o,
  output logic [ADDR_W-1:0]     step_o
);
  logic [7:0] beat;

  always_comb begin
    unique case (size_i)
      2'b00:   beat = 8'd8;
      2'b01:   beat = 8'd16;
      default: beat = 8'd32;
    endcase
    if (int'(beat) > DATA_BYTES) beat = 8'(DATA_BYTES);
  end

  assign step_o = ADDR_W'(beat);

  // final mask: MSB marks byte 0
  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
    assign be_o[i] = (i < int'(beat)) && (!last_i || tend_i[DATA_BYTES-1-i]);
  end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 32,
  parameter int CNT_W      = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [4:0]            addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      rdata_o,
  input  logic                  adv_i,
  input  logic [ADDR_W-1:0]     step_i,
  input  logic                  dec_i,
  input  logic                  set_te_i,
  input  logic                  set_sp_i,
  input  logic                  set_null_i,
  input  logic                  err_i,
  input  logic                  fte_ack_i,
  output logic                  de_o,
  output logic                  te_o,
  output logic                  dir_o,
  output logic [1:0]            size_o,
  output logic                  fte_pend_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [ADDR_W-1:0]     sar_o,
  output logic [ADDR_W-1:0]     dar_o,
  output logic [DATA_BYTES-1:0] tend_o,
  output logic                  irq_o,
  output logic                  addr_err_o
);
  logic [ADDR_W-1:0]     sar_q, dar_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [DATA_BYTES-1:0] tend_q;
  logic de_q, te_q, sp_q, dir_q, ie_q, null_q, nulle_q, fte_q, aerr_q;
  logic [1:0] size_q;
  logic wr_sar, wr_dar, wr_cnt, wr_ctl, wr_mask;
  logic [REG_W-1:0] ctl_rd;

  assign wr_sar  = we_i && (addr_i == OFF_SRC);
  assign wr_dar  = we_i && (addr_i == OFF_DST);
  assign wr_cnt  = we_i && (addr_i == OFF_CNT);
  assign wr_ctl  = we_i && (addr_i == OFF_CTL);
  assign wr_mask = we_i && (addr_i == OFF_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q  <= '0;
      dar_q  <= '0;
      cnt_q  <= '0;
      tend_q <= '0;
    end else begin
      if (wr_sar) sar_q <= ADDR_W'(wdata_i);
      else if (adv_i && dir_q) sar_q <= sar_q + step_i;
      if (wr_dar) dar_q <= ADDR_W'(wdata_i);
      else if (adv_i && !dir_q) dar_q <= dar_q + step_i;
      if (wr_cnt) cnt_q <= wdata_i[CNT_W-1:0];
      else if (dec_i) cnt_q <= cnt_q - 1'b1;
      if (wr_mask) tend_q <= wdata_i[DATA_BYTES-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q    <= 1'b0;
      te_q    <= 1'b0;
      sp_q    <= 1'b0;
      dir_q   <= 1'b0;
      ie_q    <= 1'b0;
      size_q  <= 2'b00;
      null_q  <= 1'b0;
      nulle_q <= 1'b0;
      fte_q   <= 1'b0;
      aerr_q  <= 1'b0;
    end else begin
      if (err_i) de_q <= 1'b0;
      else if (wr_ctl) de_q <= wdata_i[B_EN];
      if (wr_ctl) begin
        dir_q   <= wdata_i[B_DIR];
        ie_q    <= wdata_i[B_IE];
        size_q  <= wdata_i[B_SZ+:2];
        nulle_q <= wdata_i[B_NULLE];
      end
      // flags: hardware set beats a software clear
      if (set_te_i) te_q <= 1'b1;
      else if (wr_ctl) te_q <= te_q & wdata_i[B_END];
      if (set_sp_i) sp_q <= 1'b1;
      else if (wr_ctl) sp_q <= sp_q & wdata_i[B_STOP];
      if (set_null_i) null_q <= 1'b1;
      else if (wr_ctl) null_q <= null_q & wdata_i[B_NULL];
      if (fte_ack_i) fte_q <= 1'b0;
      else if (wr_ctl) fte_q <= wdata_i[B_FORCE];
      if (err_i) aerr_q <= 1'b1;
      else if (wr_ctl && wdata_i[B_EN]) aerr_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_rd             = '0;
    ctl_rd[B_EN]       = de_q;
    ctl_rd[B_END]      = te_q;
    ctl_rd[B_STOP]     = sp_q;
    ctl_rd[B_DIR]      = dir_q;
    ctl_rd[B_IE]       = ie_q;
    ctl_rd[B_SZ+:2]    = size_q;
    ctl_rd[B_NULL]     = null_q;
    ctl_rd[B_NULLE]    = nulle_q;
    ctl_rd[B_FORCE]    = fte_q;
  end

  always_comb begin
    unique case (addr_i)
      OFF_SRC:  rdata_o = REG_W'(sar_q);
      OFF_DST:  rdata_o = REG_W'(dar_q);
      OFF_CNT:  rdata_o = REG_W'(cnt_q);
      OFF_CTL:  rdata_o = ctl_rd;
      OFF_MASK: rdata_o = REG_W'(tend_q);
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o      = (ie_q && (te_q || sp_q)) || (nulle_q && null_q);
  assign de_o       = de_q;
  assign te_o       = te_q;
  assign dir_o      = dir_q;
  assign size_o     = size_q;
  assign fte_pend_o = fte_q;
  assign cnt_o      = cnt_q;
  assign sar_o      = sar_q;
  assign dar_o      = dar_q;
  assign tend_o     = tend_q;
  assign addr_err_o = aerr_q;

  AST_ERR_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !wr_cnt) |=> (cnt_q == $past(cnt_q))) else $error("count moved on error"); // R13
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int DATA_BYTES = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    de_i,
  input  logic                    te_i,
  input  logic                    dir_i,
  input  logic                    glob_en_i,
  input  logic                    fte_pend_i,
  input  logic                    cnt_zero_i,
  input  logic                    cnt_one_i,
  input  logic                    mem_ack_i,
  input  logic                    mem_err_i,
  input  logic [DATA_BYTES*8-1:0] mem_rdata_i,
  input  logic                    fifo_in_valid_i,
  input  logic [DATA_BYTES*8-1:0] fifo_in_data_i,
  input  logic                    fifo_null_i,
  input  logic                    fifo_out_ready_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [DATA_BYTES*8-1:0] mem_wdata_o,
  output logic                    fifo_in_ready_o,
  output logic                    fifo_out_valid_o,
  output logic [DATA_BYTES*8-1:0] fifo_out_data_o,
  output logic                    adv_o,
  output logic                    dec_o,
  output logic                    set_te_o,
  output logic                    set_sp_o,
  output logic                    set_null_o,
  output logic                    err_o,
  output logic                    fte_ack_o
);
  seq_st_e st_q, st_d;
  logic [DATA_BYTES*8-1:0] buf_q;
  logic run;

  assign run = de_i && !te_i;

  always_comb begin
    st_d             = st_q;
    mem_req_o        = 1'b0;
    fifo_in_ready_o  = 1'b0;
    fifo_out_valid_o = 1'b0;
    adv_o            = 1'b0;
    dec_o            = 1'b0;
    set_te_o         = 1'b0;
    set_sp_o         = 1'b0;
    set_null_o       = 1'b0;
    err_o            = 1'b0;
    fte_ack_o        = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (run) begin
          if (fte_pend_i) begin
            fte_ack_o = 1'b1;
            set_te_o  = 1'b1;
            set_sp_o  = 1'b1;
          end else if (cnt_zero_i) begin
            set_te_o = 1'b1;
          end else if (glob_en_i) begin
            if (!dir_i) begin
              fifo_in_ready_o = 1'b1;
              if (fifo_in_valid_i) st_d = ST_MEM;
              else if (fifo_null_i) set_null_o = 1'b1;
            end else begin
              st_d = ST_MEM;
            end
          end
        end
      end
      ST_MEM: begin
        if (!run) begin
          st_d = ST_IDLE;
        end else begin
          mem_req_o = glob_en_i;
          if (glob_en_i && mem_ack_i) begin
            if (mem_err_i) begin
              err_o = 1'b1;
              st_d  = ST_IDLE;
            end else begin
              adv_o = 1'b1;
              if (!dir_i) begin
                dec_o    = 1'b1;
                set_te_o = cnt_one_i;
                st_d     = ST_IDLE;
              end else begin
                st_d = ST_PUSH;
              end
            end
          end
        end
      end
      ST_PUSH: begin
        if (!run) begin
          st_d = ST_IDLE;
        end else begin
          fifo_out_valid_o = 1'b1;
          if (fifo_out_ready_i) begin
            dec_o    = 1'b1;
            set_te_o = cnt_one_i;
            st_d     = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      buf_q <= '0;
    end else begin
      st_q <= st_d;
      if (fifo_in_ready_o && fifo_in_valid_i) buf_q <= fifo_in_data_i;
      else if (adv_o && dir_i) buf_q <= mem_rdata_i;
    end
  end

  assign mem_we_o        = !dir_i;
  assign mem_wdata_o     = buf_q;
  assign fifo_out_data_o = buf_q;

  AST_ONE_BEAT_PER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> !mem_req_o) else $error("back-to-back beat"); // R3
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_out_valid_o && !fifo_out_ready_i && de_i) |=>
      (!de_i || (fifo_out_valid_o && $stable(fifo_out_data_o)))) else $error("fifo word dropped"); // R4
endmodule

// File: rtl/fifo_dma_chan.sv
module fifo_dma_chan
  import dmac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 32,
  parameter int CNT_W      = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    glob_en_i,
  input  logic                    reg_we_i,
  input  logic [4:0]              reg_addr_i,
  input  logic [31:0]             reg_wdata_i,
  output logic [31:0]             reg_rdata_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [DATA_BYTES-1:0]   mem_be_o,
  output logic [DATA_BYTES*8-1:0] mem_wdata_o,
  input  logic                    mem_ack_i,
  input  logic                    mem_err_i,
  input  logic [DATA_BYTES*8-1:0] mem_rdata_i,
  input  logic                    fifo_in_valid_i,
  input  logic [DATA_BYTES*8-1:0] fifo_in_data_i,
  output logic                    fifo_in_ready_o,
  input  logic                    fifo_null_i,
  output logic                    fifo_out_valid_o,
  output logic [DATA_BYTES*8-1:0] fifo_out_data_o,
  input  logic                    fifo_out_ready_i,
  output logic                    irq_o,
  output logic                    addr_err_o
);
  logic de, te, dir, fte_pend;
  logic [1:0] size;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] sar, dar, step;
  logic [DATA_BYTES-1:0] tend;
  logic adv, dec, set_te, set_sp, set_null, err, fte_ack;
  logic last;

  assign last = (cnt == CNT_W'(1));

  dmac_regs #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .adv_i(adv), .step_i(step), .dec_i(dec), .set_te_i(set_te), .set_sp_i(set_sp),
    .set_null_i(set_null), .err_i(err), .fte_ack_i(fte_ack),
    .de_o(de), .te_o(te), .dir_o(dir), .size_o(size), .fte_pend_o(fte_pend),
    .cnt_o(cnt), .sar_o(sar), .dar_o(dar), .tend_o(tend),
    .irq_o(irq_o), .addr_err_o(addr_err_o)
  );

  dmac_lanes #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_lanes (
    .size_i(size), .last_i(last), .tend_i(tend), .be_o(mem_be_o), .step_o(step)
  );

  dmac_seq #(.DATA_BYTES(DATA_BYTES)) u_seq (
    .clk_i, .rst_ni,
    .de_i(de), .te_i(te), .dir_i(dir), .glob_en_i(glob_en_i), .fte_pend_i(fte_pend),
    .cnt_zero_i(cnt == '0), .cnt_one_i(last),
    .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i), .mem_rdata_i(mem_rdata_i),
    .fifo_in_valid_i(fifo_in_valid_i), .fifo_in_data_i(fifo_in_data_i),
    .fifo_null_i(fifo_null_i), .fifo_out_ready_i(fifo_out_ready_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .fifo_in_ready_o(fifo_in_ready_o), .fifo_out_valid_o(fifo_out_valid_o),
    .fifo_out_data_o(fifo_out_data_o),
    .adv_o(adv), .dec_o(dec), .set_te_o(set_te), .set_sp_o(set_sp),
    .set_null_o(set_null), .err_o(err), .fte_ack_o(fte_ack)
  );

  assign mem_addr_o = dir ? sar : dar;

  AST_END_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    te |-> !mem_req_o) else $error("request after end"); // R5
  AST_ERR_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && mem_err_i && !(reg_we_i && reg_addr_i == OFF_CTL))
      |=> (!de && addr_err_o)) else $error("error did not halt"); // R13
endmodule

// File: tb/fifo_dma_chan_tb.sv
module fifo_dma_chan_tb;
  localparam int DB = 32;
  localparam int DW = DB * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glob_en = 1'b1;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr;
  logic [DB-1:0] mem_be;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic fifo_in_valid = 1'b0;
  logic fifo_null = 1'b0;
  logic fifo_in_ready, fifo_out_valid;
  logic fifo_out_ready = 1'b1;
  logic [DW-1:0] fifo_out_data;
  logic irq, addr_err;
  logic err_en = 1'b0;
  localparam logic [DW-1:0] IN_WORD = {8{32'hCAFE_F00D}};

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  assign mem_ack   = mem_req;
  assign mem_err   = mem_req & err_en;
  assign mem_rdata = {8{mem_addr}};

  fifo_dma_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .glob_en_i(glob_en),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
    .fifo_in_valid_i(fifo_in_valid), .fifo_in_data_i(IN_WORD), .fifo_in_ready_o(fifo_in_ready),
    .fifo_null_i(fifo_null), .fifo_out_valid_o(fifo_out_valid), .fifo_out_data_o(fifo_out_data),
    .fifo_out_ready_i(fifo_out_ready), .irq_o(irq), .addr_err_o(addr_err)
  );

  // request / push logs, sampled after inputs settle
  logic [31:0]   la  [64];
  logic [DB-1:0] lbe [64];
  logic          lwe [64];
  logic [DW-1:0] lwd [64];
  logic [DW-1:0] pd  [64];
  int ln = 0;
  int pn = 0;

  always @(negedge clk) begin
    #1;
    if (mem_req && mem_ack && ln < 64) begin
      la[ln] = mem_addr; lbe[ln] = mem_be; lwe[ln] = mem_we; lwd[ln] = mem_wdata;
      ln = ln + 1;
    end
    if (fifo_out_valid && fifo_out_ready && pn < 64) begin
      pd[pn] = fifo_out_data;
      pn = pn + 1;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam int NT = 7;
  localparam logic [4:0]  T_A [NT] = '{5'h00, 5'h04, 5'h08, 5'h18, 5'h08, 5'h14, 5'h0C};
  localparam logic [31:0] T_W [NT] = '{32'hDEADBEEF, 32'h12345678, 32'hFFFFFFFF,
                                       32'hF8000000, 32'h00000003, 32'h000100A6, 32'h55555555};
  localparam logic [31:0] T_E [NT] = '{32'hDEADBEEF, 32'h12345678, 32'h00FFFFFF,
                                       32'hF8000000, 32'h00000003, 32'h000100A0, 32'h00000000};

  initial begin
    logic [31:0] v;
    int b;
    #10;
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), v);
      chk("R1 reg reset", DW'(v), '0);
    end
    chk("R1 outputs idle", DW'({irq, addr_err, mem_req, fifo_in_ready, fifo_out_valid}), '0);

    // R2 register map table (last control write also checks R10 write-1 keeps)
    for (int t = 0; t < NT; t++) begin
      wr(T_A[t], T_W[t]);
      rd(T_A[t], v);
      chk($sformatf("R2 table row %0d", t), DW'(v), DW'(T_E[t]));
    end
    wr(5'h14, 32'h0);

    // R3 R5 R6 R11: FIFO-to-memory, 3 beats, 5-byte last beat
    b = ln;
    fifo_in_valid = 1'b1;
    wr(5'h04, 32'h0000_1000);
    wr(5'h00, 32'h0000_0AA0);
    wr(5'h08, 32'd3);
    wr(5'h18, 32'hF800_0000);
    wr(5'h14, 32'h0000_00A1);
    wait_cyc(20);
    fifo_in_valid = 1'b0;
    chk("R3 beat count", DW'(ln - b), DW'(3));
    chk("R3 addr0", DW'(la[b]), DW'(32'h1000));
    chk("R3 addr1", DW'(la[b+1]), DW'(32'h1020));
    chk("R3 addr2", DW'(la[b+2]), DW'(32'h1040));
    chk("R3 write dir", DW'({lwe[b], lwe[b+2]}), DW'(2'b11));
    chk("R3 write data", lwd[b], IN_WORD);
    chk("R6 full lanes", DW'(lbe[b+1]), DW'(32'hFFFF_FFFF));
    chk("R6 last lanes", DW'(lbe[b+2]), DW'(32'h0000_001F));
    rd(5'h04, v); chk("R3 dst advanced", DW'(v), DW'(32'h1060));
    rd(5'h00, v); chk("R3 src unchanged", DW'(v), DW'(32'h0AA0));
    rd(5'h08, v); chk("R5 count zero", DW'(v), '0);
    rd(5'h14, v); chk("R5 end flag", DW'(v), DW'(32'hA3));
    chk("R11 irq on end", DW'(irq), DW'(1));
    wr(5'h14, 32'h0000_00A3);
    rd(5'h14, v); chk("R10 write-1 keeps end", DW'(v), DW'(32'hA3));
    wr(5'h14, 32'h0);
    #1;
    chk("R10 R11 cleared", DW'({irq, reg_rdata[1]}), '0);

    // R5 enable with zero count
    b = ln;
    wr(5'h14, 32'h81);
    wait_cyc(3);
    rd(5'h14, v); chk("R5 zero count end", DW'(v), DW'(32'h83));
    chk("R5 zero count no req", DW'(ln - b), '0);
    wr(5'h14, 32'h0);

    // R4 R7 R6: memory-to-FIFO, 8-byte beats
    b = ln;
    wr(5'h00, 32'h0000_2000);
    wr(5'h08, 32'd2);
    wr(5'h18, 32'hC000_0000);
    wr(5'h14, 32'h0000_0009);
    wait_cyc(20);
    chk("R4 read count", DW'(ln - b), DW'(2));
    chk("R4 read addrs", DW'({la[b], la[b+1]}), DW'({32'h2000, 32'h2008}));
    chk("R4 read dir", DW'({lwe[b], lwe[b+1]}), '0);
    chk("R7 8-byte lanes", DW'(lbe[b]), DW'(32'h0000_00FF));
    chk("R6 R7 last lanes", DW'(lbe[b+1]), DW'(32'h0000_0003));
    chk("R4 push data0", pd[pn-2], {8{32'h2000}});
    chk("R4 push data1", pd[pn-1], {8{32'h2008}});
    rd(5'h00, v); chk("R7 src step 8", DW'(v), DW'(32'h2010));
    rd(5'h08, v); chk("R4 count zero", DW'(v), '0);
    chk("R11 no irq when IE off", DW'(irq), '0);
    wr(5'h14, 32'h0);

    // R7 16-byte step
    b = ln;
    wr(5'h00, 32'h0000_2400);
    wr(5'h08, 32'd2);
    wr(5'h14, 32'h0000_0049);
    wait_cyc(20);
    chk("R7 16-byte lanes", DW'(lbe[b]), DW'(32'h0000_FFFF));
    rd(5'h00, v); chk("R7 src step 16", DW'(v), DW'(32'h2420));
    wr(5'h14, 32'h0);

    // R12 global enable
    b = ln;
    glob_en = 1'b0;
    wr(5'h00, 32'h0000_3000);
    wr(5'h08, 32'd1);
    wr(5'h14, 32'h0000_0089);
    wait_cyc(10);
    chk("R12 no req when off", DW'(ln - b), '0);
    rd(5'h08, v); chk("R12 count held", DW'(v), DW'(1));
    glob_en = 1'b1;
    wait_cyc(10);
    chk("R12 req after on", DW'(ln - b), DW'(1));
    chk("R12 pushed word", pd[pn-1], {8{32'h3000}});
    wr(5'h14, 32'h0);

    // R8 R9 R11: null report then forced end
    b = ln;
    fifo_null = 1'b1;
    wr(5'h08, 32'd5);
    wr(5'h14, 32'h0001_0081);
    wait_cyc(3);
    rd(5'h14, v); chk("R8 null flag", DW'(v), DW'(32'h0001_1081));
    chk("R8 R11 null irq", DW'(irq), DW'(1));
    fifo_null = 1'b0;
    wr(5'h14, 32'h0001_0081);
    rd(5'h14, v); chk("R10 null cleared", DW'(v), DW'(32'h0001_0081));
    chk("R11 irq dropped", DW'(irq), '0);
    wr(5'h14, 32'h0101_0081);
    wait_cyc(3);
    rd(5'h14, v); chk("R9 forced end", DW'(v), DW'(32'h0001_0087));
    chk("R9 no request", DW'(ln - b), '0);
    rd(5'h08, v); chk("R9 count kept", DW'(v), DW'(5));
    wr(5'h14, 32'h0000_0024);
    #1;
    chk("R11 stop flag irq", DW'({irq, reg_rdata[2:1]}), DW'(3'b110));
    wr(5'h14, 32'h0);

    // R13 bus error
    b = ln;
    err_en = 1'b1;
    wr(5'h00, 32'h0000_5000);
    wr(5'h08, 32'd2);
    wr(5'h14, 32'h0000_0089);
    wait_cyc(6);
    err_en = 1'b0;
    chk("R13 one failed beat", DW'(ln - b), DW'(1));
    chk("R13 error flag", DW'(addr_err), DW'(1));
    rd(5'h14, v); chk("R13 enable cleared", DW'(v), DW'(32'h88));
    rd(5'h00, v); chk("R13 addr kept", DW'(v), DW'(32'h5000));
    wr(5'h14, 32'h0000_0088);
    #1; chk("R13 flag sticky", DW'(addr_err), DW'(1));
    wr(5'h14, 32'h0000_0089);
    #1; chk("R13 flag released", DW'(addr_err), '0);
    wait_cyc(10);
    wr(5'h14, 32'h0);

    // R14 abort while a word waits for the FIFO
    fifo_out_ready = 1'b0;
    wr(5'h00, 32'h0000_6000);
    wr(5'h08, 32'd2);
    b = ln;
    wr(5'h14, 32'h0000_0089);
    wait_cyc(5);
    chk("R14 stalled on push", DW'({fifo_out_valid, 6'(ln - b)}), DW'({1'b1, 6'd1}));
    b = pn;
    wr(5'h14, 32'h0);
    fifo_out_ready = 1'b1;
    wait_cyc(5);
    chk("R14 no push after abort", DW'(pn - b), '0);
    rd(5'h08, v); chk("R14 count kept", DW'(v), DW'(2));
    chk("R14 no request", DW'(mem_req), '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule